// File: doc/BRIEF.md
# Circular-Buffer LMS Noise Canceller

This block is an adaptive FIR noise canceller that works through its taps one at a time on a single multiply-accumulate path. It keeps two circular buffers: one holds the reference-noise history and one holds the coefficients. Each buffer is walked by a pointer that wraps modulo the tap count. The history buffer is never shifted. Each new sample is written where the history pointer rests, and one pointer decrement at the end of the sample's work makes the next sample land on the oldest entry.

For each accepted pair (reference sample x, primary sample d), the engine runs these steps in order:
- It accumulates the filter output y in Q15 over all taps and rounds the result convergently.
- It forms the error e = d - y.
- It scales the error once by a loop gain.
- It runs a second pass over the taps that updates every coefficient.

The block reports y and e with a one-cycle done strobe. The coefficients and the gain are loaded through small write ports that only take effect while the engine is idle.

Top module: `lms_engine`

## Requirements
- R1: After reset, samp_ready is 1, done is 0, y_out and err_out are 0, and every coefficient and history entry is 0.
- R2: A sample pair is taken only on a clock edge where samp_valid and samp_ready are both 1. samp_ready stays 0 until the result is posted. samp_valid while busy is ignored and is not queued.
- R3: The output is y = sat16(rne15(sum over i of b_i * x(n-i))). The coefficient written at coef_addr i weights the sample taken i samples earlier (i = 0 is the current one). Products are Q30 and are summed at full width.
- R4: The error is err_out = sat16(d - y), a 16-bit two's-complement value clamped to [-32768, 32767].
- R5: After y is formed, the engine computes g = sat16(rne15(K * e)). Every coefficient then becomes b_i = sat16(b_i + rne15(g * x(n-i))). The new coefficients apply from the next sample on.
- R6: The history holds the last NTAPS samples and starts as zeros. A sample older than NTAPS-1 steps has no further effect on y.
- R7: done is a one-cycle pulse that rises 2*NTAPS+4 clock edges after the accepting edge, while samp_ready is 1. y_out and err_out keep their values until the next result.
- R8: Writes through coef_we and gain_we take effect only when samp_ready is 1. While busy they are ignored.
- R9: rne15 is convergent rounding. It shifts right by 15 bits, and an exact half rounds to the even result. For example, 3*16384 gives 2, 1*16384 gives 0 and 1*(-16384) gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_valid | input | 1 | Sample pair offered |
| samp_ready | output | 1 | Engine idle, pair can be taken |
| samp_x | input | DW | Reference noise sample, Q15 |
| samp_d | input | DW | Primary input sample, Q15 |
| gain_we | input | 1 | Load loop gain (idle only) |
| gain_val | input | DW | Loop gain K, Q15 |
| coef_we | input | 1 | Coefficient write strobe (idle only) |
| coef_addr | input | AW | Tap index of the write |
| coef_val | input | DW | Coefficient value, Q15 |
| y_out | output | DW | Filter output |
| err_out | output | DW | Error output |
| done | output | 1 | Result posted, one cycle |

## Verification
If a pointer wraps or steps wrongly, history samples pair with the wrong coefficients. With a single non-zero tap, this shows as an impulse surfacing at the wrong delay, within NTAPS samples. A wrong coefficient write-back or gain product stays invisible on the current sample but corrupts y from the next sample on, and the error keeps growing over a random run. Rounding and clamping faults show at once on directed tie and full-scale vectors.

// File: rtl/lms_pkg.sv
package lms_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CLR,
      PH_MAC,
      PH_ERR,
      PH_GAIN,
      PH_UPD,
      PH_STEP
   } phase_t;
endpackage

// File: rtl/lms_modptr.sv
module lms_modptr #(
   parameter int N  = 8,
   parameter int AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   output logic [AW-1:0] ptr
);
   localparam logic [AW-1:0] LAST = AW'(N - 1);
   logic [AW-1:0] nxt_up, nxt_dn;

   generate
      if ((N & (N - 1)) == 0) begin : g_pow2
         // range fills the pointer width: natural wrap
         assign nxt_up = ptr + 1'b1;
         assign nxt_dn = ptr - 1'b1;
      end else begin : g_cmp
         assign nxt_up = (ptr == LAST) ? '0 : ptr + 1'b1;
         assign nxt_dn = (ptr == '0) ? LAST : ptr - 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   ptr <= '0;
      else if (inc) ptr <= nxt_up;
      else if (dec) ptr <= nxt_dn;
   end
endmodule

// File: rtl/lms_datapath.sv
module lms_datapath #(
   parameter int DW   = 16,
   parameter int ACCW = 40
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_clr,
   input  logic                 acc_en,
   input  logic signed [DW-1:0] st_rd,
   input  logic signed [DW-1:0] cf_rd,
   input  logic signed [DW-1:0] d_in,
   input  logic signed [DW-1:0] k_in,
   input  logic signed [DW-1:0] e_in,
   input  logic signed [DW-1:0] g_in,
   output logic signed [DW-1:0] y_calc,
   output logic signed [DW-1:0] e_calc,
   output logic signed [DW-1:0] g_calc,
   output logic signed [DW-1:0] cf_new
);
   localparam int F = DW - 1;
   localparam longint MAXV = (64'sd1 <<< (DW - 1)) - 1;
   localparam longint MINV = -(64'sd1 <<< (DW - 1));

   function automatic logic signed [ACCW-1:0] sx(input logic signed [DW-1:0] v);
      return {{(ACCW-DW){v[DW-1]}}, v};
   endfunction

   function automatic logic signed [ACCW-1:0] mul(input logic signed [DW-1:0] a,
                                                  input logic signed [DW-1:0] b);
      logic signed [2*DW-1:0] p;
      p = a * b;
      return {{(ACCW-2*DW){p[2*DW-1]}}, p};
   endfunction

   // shift by F, exact half goes to the even neighbour
   function automatic logic signed [ACCW-1:0] rne(input logic signed [ACCW-1:0] v);
      logic signed [ACCW-1:0] q;
      logic [F-1:0] rem;
      q   = v >>> F;
      rem = v[F-1:0];
      if (rem > (F'(1) << (F - 1)) || (rem == (F'(1) << (F - 1)) && q[0]))
         q = q + 1'b1;
      return q;
   endfunction

   function automatic logic signed [DW-1:0] sat(input logic signed [ACCW-1:0] v);
      if (v > ACCW'(MAXV)) return DW'(MAXV);
      if (v < ACCW'(MINV)) return DW'(MINV);
      return v[DW-1:0];
   endfunction

   logic signed [ACCW-1:0] acc;

   always_ff @(posedge clk) begin
      if (!rst_n || acc_clr) acc <= '0;
      else if (acc_en)       acc <= acc + mul(st_rd, cf_rd);
   end

   always_comb begin
      y_calc = sat(rne(acc));
      e_calc = sat(sx(d_in) - sx(y_calc));
      g_calc = sat(rne(mul(k_in, e_in)));
      cf_new = sat(sx(cf_rd) + rne(mul(g_in, st_rd)));
   end
endmodule

// File: rtl/lms_engine.sv
module lms_engine #(
   parameter int NTAPS = 8,
   parameter int DW    = 16,
   parameter int ACCW  = 40,
   localparam int AW   = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 samp_valid,
   output logic                 samp_ready,
   input  logic signed [DW-1:0] samp_x,
   input  logic signed [DW-1:0] samp_d,
   input  logic                 gain_we,
   input  logic signed [DW-1:0] gain_val,
   input  logic                 coef_we,
   input  logic [AW-1:0]        coef_addr,
   input  logic signed [DW-1:0] coef_val,
   output logic signed [DW-1:0] y_out,
   output logic signed [DW-1:0] err_out,
   output logic                 done
);
   import lms_pkg::*;

   generate
      if (NTAPS < 2) begin : g_bad_taps
         $error("lms_engine: NTAPS must be at least 2");
      end
      if (ACCW <= 2 * DW) begin : g_bad_acc
         $error("lms_engine: ACCW must exceed twice DW");
      end
   endgenerate

   localparam logic [AW-1:0] LAST = AW'(NTAPS - 1);

   phase_t              ph;
   logic [AW-1:0]       cnt;
   logic [AW-1:0]       s_ptr, c_ptr;
   logic signed [DW-1:0] sbuf [NTAPS];
   logic signed [DW-1:0] cbuf [NTAPS];
   logic signed [DW-1:0] x_q, d_q, k_q, g_q;
   logic signed [DW-1:0] y_calc, e_calc, g_calc, cf_new;
   logic                 walk;

   assign walk       = (ph == PH_MAC) || (ph == PH_UPD);
   assign samp_ready = (ph == PH_IDLE);

   lms_modptr #(.N(NTAPS), .AW(AW)) u_sptr (
      .clk(clk), .rst_n(rst_n), .inc(walk), .dec(ph == PH_STEP), .ptr(s_ptr));

   lms_modptr #(.N(NTAPS), .AW(AW)) u_cptr (
      .clk(clk), .rst_n(rst_n), .inc(walk), .dec(1'b0), .ptr(c_ptr));

   lms_datapath #(.DW(DW), .ACCW(ACCW)) u_dp (
      .clk(clk), .rst_n(rst_n),
      .acc_clr(ph == PH_CLR), .acc_en(ph == PH_MAC),
      .st_rd(sbuf[s_ptr]), .cf_rd(cbuf[c_ptr]),
      .d_in(d_q), .k_in(k_q), .e_in(err_out), .g_in(g_q),
      .y_calc(y_calc), .e_calc(e_calc), .g_calc(g_calc), .cf_new(cf_new));

   // buffers: sample lands at the state pointer, coefficients written back in place
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NTAPS; i++) begin
            sbuf[i] <= '0;
            cbuf[i] <= '0;
         end
      end else begin
         if (ph == PH_CLR) sbuf[s_ptr] <= x_q;
         if (ph == PH_UPD) cbuf[c_ptr] <= cf_new;
         else if (samp_ready && coef_we && (int'(coef_addr) < NTAPS))
            cbuf[coef_addr] <= coef_val;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         cnt     <= '0;
         x_q     <= '0;
         d_q     <= '0;
         k_q     <= '0;
         g_q     <= '0;
         y_out   <= '0;
         err_out <= '0;
         done    <= 1'b0;
      end else begin
         done <= (ph == PH_STEP);
         unique case (ph)
            PH_IDLE: begin
               if (gain_we) k_q <= gain_val;
               if (samp_valid) begin
                  x_q <= samp_x;
                  d_q <= samp_d;
                  ph  <= PH_CLR;
               end
            end
            PH_CLR: begin
               cnt <= '0;
               ph  <= PH_MAC;
            end
            PH_MAC: begin
               cnt <= cnt + 1'b1;
               if (cnt == LAST) ph <= PH_ERR;
            end
            PH_ERR: begin
               y_out   <= y_calc;
               err_out <= e_calc;
               ph      <= PH_GAIN;
            end
            PH_GAIN: begin
               g_q <= g_calc;
               cnt <= '0;
               ph  <= PH_UPD;
            end
            PH_UPD: begin
               cnt <= cnt + 1'b1;
               if (cnt == LAST) ph <= PH_STEP;
            end
            PH_STEP: ph <= PH_IDLE;
            default: ph <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lms_engine_chk.sv
module lms_engine_chk #(
   parameter int NTAPS = 8,
   parameter int DW    = 16,
   parameter int AW    = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          samp_valid,
   input logic          samp_ready,
   input logic          done,
   input logic [DW-1:0] y_out,
   input logic [DW-1:0] err_out,
   input logic [AW-1:0] s_ptr
);
   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> samp_ready);

   p_take_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_valid && samp_ready) |=> !samp_ready);

   p_ptr_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && done) |-> (s_ptr == (($past(s_ptr) == '0) ? AW'(NTAPS - 1)
                                                          : $past(s_ptr) - 1'b1)));

   p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(s_ptr) < NTAPS);

   p_hold_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && samp_ready && !done) |-> ($stable(y_out) && $stable(err_out)));
endmodule

bind lms_engine lms_engine_chk #(.NTAPS(NTAPS), .DW(DW), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_ready(samp_ready),
   .done(done), .y_out(y_out), .err_out(err_out), .s_ptr(s_ptr));

// File: tb/lms_engine_bench.sv
`timescale 1ns/1ps
module lms_engine_bench;
   localparam int N  = 8;
   localparam int DW = 16;
   localparam int AW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic samp_valid = 1'b0;
   logic samp_ready;
   logic signed [DW-1:0] samp_x = '0, samp_d = '0;
   logic gain_we = 1'b0;
   logic signed [DW-1:0] gain_val = '0;
   logic coef_we = 1'b0;
   logic [AW-1:0] coef_addr = '0;
   logic signed [DW-1:0] coef_val = '0;
   logic signed [DW-1:0] y_out, err_out;
   logic done;

   always #10 clk = ~clk;

   lms_engine #(.NTAPS(N), .DW(DW), .ACCW(40)) u_lms_engine (
      .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_ready(samp_ready),
      .samp_x(samp_x), .samp_d(samp_d), .gain_we(gain_we), .gain_val(gain_val),
      .coef_we(coef_we), .coef_addr(coef_addr), .coef_val(coef_val),
      .y_out(y_out), .err_out(err_out), .done(done));

   int n_chk = 0, n_bad = 0;
   longint m_hist [N];
   longint m_coef [N];
   longint m_k = 0;
   longint m_y, m_e;

   function automatic longint rne(longint v);
      longint q = v >>> 15;
      longint rem = v & 32767;
      if (rem > 16384 || (rem == 16384 && (q & 1) != 0)) q = q + 1;
      return q;
   endfunction

   function automatic longint sat(longint v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_step(input longint x, input longint d);
      longint acc = 0, g;
      for (int i = N - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = x;
      for (int i = 0; i < N; i++) acc += m_coef[i] * m_hist[i];
      m_y = sat(rne(acc));
      m_e = sat(d - m_y);
      g = sat(rne(m_k * m_e));
      for (int i = 0; i < N; i++) m_coef[i] = sat(m_coef[i] + rne(g * m_hist[i]));
   endtask

   task automatic set_gain(input longint k);
      @(negedge clk);
      gain_we = 1'b1; gain_val = DW'(k);
      @(negedge clk);
      gain_we = 1'b0;
      m_k = k;
   endtask

   task automatic set_coef(input int a, input longint v);
      @(negedge clk);
      coef_we = 1'b1; coef_addr = AW'(a); coef_val = DW'(v);
      @(negedge clk);
      coef_we = 1'b0;
      m_coef[a] = v;
   endtask

   // apply one pair, wait for done, check latency and outputs against the model
   task automatic apply(input longint x, input longint d, input bit busy_poke);
      int cyc = 0;
      @(negedge clk);
      samp_valid = 1'b1; samp_x = DW'(x); samp_d = DW'(d);
      model_step(x, d);
      @(negedge clk);
      cyc = 1;
      samp_valid = 1'b0;
      if (busy_poke) begin
         samp_valid = 1'b1; samp_x = 16'sd12345; samp_d = 16'sd321;
         coef_we = 1'b1; coef_addr = '0; coef_val = 16'sd20000;
         gain_we = 1'b1; gain_val = 16'sd30000;
      end
      while (!done && cyc < 4 * N + 20) begin
         @(negedge clk);
         cyc++;
         samp_valid = 1'b0; coef_we = 1'b0; gain_we = 1'b0;
      end
      chk(cyc == 2 * N + 5, "R7 latency", cyc - 1, 2 * N + 4);
      chk(longint'(y_out) == m_y, "R3 y", y_out, m_y);
      chk(longint'(err_out) == m_e, "R4 e", err_out, m_e);
   endtask

   task automatic flush();
      longint ks = m_k;
      set_gain(0);
      for (int i = 0; i < N; i++) apply(0, 0, 1'b0);
      set_gain(ks);
   endtask

   initial begin
      int unsigned seed_set;
      int gap;
      seed_set = $urandom(32'd4711);
      for (int i = 0; i < N; i++) begin m_hist[i] = 0; m_coef[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(samp_ready == 1'b1, "R1 ready", samp_ready, 1);
      chk(done == 1'b0, "R1 done", done, 0);
      chk(y_out == 0 && err_out == 0, "R1 outputs", y_out, 0);
      apply(30000, 1000, 1'b0);
      chk(y_out == 0, "R1 zero coefficients", y_out, 0);
      chk(err_out == 1000, "R4 e equals d", err_out, 1000);
      chk(done == 1'b1, "R7 done high", done, 1);
      @(negedge clk);
      chk(done == 1'b0, "R7 done one cycle", done, 0);

      // R9 convergent rounding ties
      flush();
      set_coef(0, 3);
      apply(16384, 0, 1'b0);
      chk(y_out == 2, "R9 tie 1.5 to 2", y_out, 2);
      set_coef(0, 1);
      apply(16384, 0, 1'b0);
      chk(y_out == 0, "R9 tie 0.5 to 0", y_out, 0);
      apply(-16384, 0, 1'b0);
      chk(y_out == 0, "R9 tie -0.5 to 0", y_out, 0);

      // R6 impulse surfaces at the last tap only
      set_coef(0, 0);
      set_coef(N - 1, 16384);
      flush();
      apply(20000, 0, 1'b0);
      for (int i = 1; i < N; i++) apply(0, 0, 1'b0);
      chk(y_out == 10000, "R6 impulse at last tap", y_out, 10000);
      apply(0, 0, 1'b0);
      chk(y_out == 0, "R6 impulse dropped", y_out, 0);

      // R3/R4 saturation at full scale
      for (int i = 0; i < N; i++) set_coef(i, 32767);
      for (int i = 0; i < N; i++) apply(32767, -32768, 1'b0);
      chk(y_out == 32767, "R3 y clamps high", y_out, 32767);
      chk(err_out == -32768, "R4 e clamps low", err_out, -32768);

      // R8/R2 writes and offers while busy are ignored
      for (int i = 0; i < N; i++) set_coef(i, 1000 * (i + 1));
      set_gain(4096);
      apply(5000, 7000, 1'b1);
      gap = 0;
      for (int i = 0; i < 2 * N + 8; i++) begin
         @(negedge clk);
         if (done) gap++;
      end
      chk(gap == 0, "R2 busy offer not queued", gap, 0);
      apply(-3000, 2000, 1'b0);
      apply(1200, -800, 1'b0);

      // R5 random adaptation run
      set_gain(longint'($urandom_range(0, 6000)));
      for (int i = 0; i < N; i++) set_coef(i, longint'($urandom_range(0, 8000)) - 4000);
      for (int s = 0; s < 300; s++) begin
         longint xr = longint'($urandom_range(0, 40000)) - 20000;
         longint dr = longint'($urandom_range(0, 40000)) - 20000;
         apply(xr, dr, (s % 37) == 5);
         if (s % 50 == 49) begin
            set_coef(s % N, longint'($urandom_range(0, 2000)));
            set_gain(longint'($urandom_range(0, 8000)));
         end
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 190000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule